// File: doc/BRIEF.md
# Interrupt Status and Mask Register Set

This block collects interrupt sources for a serial controller and presents them to software through a small register window. Each of seven sources drives one event input. While an event input is high, the matching status bit is set. Software clears a status bit by writing a one to it. The mask is never written directly. Software sets mask bits through a write-one-to-set register and clears them through a write-one-to-clear register. A read-only view shows the current mask.

One registered interrupt line is raised whenever any status bit is set and its mask bit is also set. The line follows the state of the registers one clock later. Every register uses the same bit layout:

| Bit | Source |
|-----|--------|
| 1 | mode fault |
| 2 | transmit level below watermark |
| 3 | transmit full |
| 4 | receive not empty |
| 0, 5, 6 | general sources |

Writing 0x7F to a register addresses all seven sources.

A normal service routine reads the status register and writes the same value back. This clears exactly the events it saw. An event that arrives during the write-back stays pending.

Top module: `irq_regset`

## Requirements
- R1: After reset, status, mask and irq are zero, and every offset reads zero.
- R2: A high level on src_evt[i] during a clock edge sets status bit i. Status reads at offset 0x04 in bits [6:0]. The bit layout is 1 = mode fault, 2 = transmit below watermark, 3 = transmit full, 4 = receive not empty; bits 0, 5 and 6 are general sources.
- R3: A write to offset 0x04 clears each status bit whose write-data bit is one. Status bits whose write-data bit is zero are unchanged.
- R4: If src_evt[i] is high in the same cycle that a write to 0x04 clears bit i, the bit ends up set.
- R5: A write to offset 0x08 sets each mask bit whose write-data bit is one. Zero bits leave the mask unchanged.
- R6: A write to offset 0x0C clears each mask bit whose write-data bit is one. Zero bits leave the mask unchanged.
- R7: The mask reads at offset 0x10 in bits [6:0]. Writes to offset 0x10 leave the mask unchanged.
- R8: Reads of offsets 0x08 and 0x0C return zero. Bits [31:7] of every read are zero.
- R9: After each clock edge, irq equals the OR over i of (status[i] AND mask[i]) as it was before that edge.
- R10: Writing a previously read status value back to 0x04 clears exactly those bits. An event arriving in the write cycle stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe for the current access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_evt | input | 7 | Per-source event inputs; a high level sets status |
| irq | output | 1 | Registered interrupt request |

## Verification
A hardware event and a software write-one-to-clear can land on the same status bit in the same clock. The bench provokes this for every source bit by raising that event during a write of 0x7F to the status offset. The status read afterwards must show exactly the events of that cycle, because setting wins. The same clash appears in the write-back case: a read value is written back while a new event on a different bit arrives. That new bit must survive while the read bits are cleared.

// File: rtl/irq_regset_pkg.sv
package irq_regset_pkg;

   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_STAT = 3'd1,
      SEL_SET  = 3'd2,
      SEL_CLR  = 3'd3,
      SEL_MASK = 3'd4
   } reg_sel_e;

   localparam int SRC_MODE_FAULT = 1;
   localparam int SRC_TX_LOW     = 2;
   localparam int SRC_TX_FULL    = 3;
   localparam int SRC_RX_AVAIL   = 4;

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
   import irq_regset_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int STAT_OFS = 4,
   parameter int SET_OFS  = 8,
   parameter int CLR_OFS  = 12,
   parameter int MASK_OFS = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(SET_OFS);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_OFS);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);

   always_comb begin
      if (addr == A_STAT)      sel = SEL_STAT;
      else if (addr == A_SET)  sel = SEL_SET;
      else if (addr == A_CLR)  sel = SEL_CLR;
      else if (addr == A_MASK) sel = SEL_MASK;
      else                     sel = SEL_NONE;
   end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int NUM_SRC = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic               clr_en,
   input  logic [NUM_SRC-1:0] clr_bits,
   output logic [NUM_SRC-1:0] stat_q
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stat_q[i] <= 1'b0;
         else if (evt[i])
            stat_q[i] <= 1'b1;
         else if (clr_en && clr_bits[i])
            stat_q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int NUM_SRC = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic               clr_en,
   input  logic [NUM_SRC-1:0] bits,
   output logic [NUM_SRC-1:0] mask_q
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_q[i] <= 1'b0;
         else if (set_en && bits[i])
            mask_q[i] <= 1'b1;
         else if (clr_en && bits[i])
            mask_q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_regset.sv
module irq_regset
   import irq_regset_pkg::*;
#(
   parameter int NUM_SRC  = 7,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int STAT_OFS = 4,
   parameter int SET_OFS  = 8,
   parameter int CLR_OFS  = 12,
   parameter int MASK_OFS = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_we,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_SRC-1:0] src_evt,
   output logic               irq
);
   localparam int PAD_W = DATA_W - NUM_SRC;

   initial begin
      assert (NUM_SRC >= 1 && NUM_SRC <= DATA_W)
         else $error("irq_regset: NUM_SRC out of range");
      assert (STAT_OFS != SET_OFS && STAT_OFS != CLR_OFS && STAT_OFS != MASK_OFS &&
              SET_OFS != CLR_OFS && SET_OFS != MASK_OFS && CLR_OFS != MASK_OFS)
         else $error("irq_regset: register offsets overlap");
      assert (((STAT_OFS | SET_OFS | CLR_OFS | MASK_OFS) % 4) == 0)
         else $error("irq_regset: offsets must be word aligned");
   end

   reg_sel_e           sel;
   logic [NUM_SRC-1:0] wbits;
   logic [NUM_SRC-1:0] stat_q;
   logic [NUM_SRC-1:0] mask_q;
   logic               wr_stat, wr_set, wr_clr;

   assign wbits   = reg_wdata[NUM_SRC-1:0];
   assign wr_stat = reg_we && (sel == SEL_STAT);
   assign wr_set  = reg_we && (sel == SEL_SET);
   assign wr_clr  = reg_we && (sel == SEL_CLR);

   if (PAD_W > 0) begin : g_pad
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_SRC];
   end

   irq_addr_dec #(
      .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .SET_OFS(SET_OFS),
      .CLR_OFS(CLR_OFS), .MASK_OFS(MASK_OFS)
   ) u_dec (
      .addr(reg_addr),
      .sel (sel)
   );

   irq_status_bank #(.NUM_SRC(NUM_SRC)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (src_evt),
      .clr_en  (wr_stat),
      .clr_bits(wbits),
      .stat_q  (stat_q)
   );

   irq_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .set_en(wr_set),
      .clr_en(wr_clr),
      .bits  (wbits),
      .mask_q(mask_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(stat_q & mask_q);
   end

   always_comb begin
      reg_rdata = '0;
      case (sel)
         SEL_STAT: reg_rdata[NUM_SRC-1:0] = stat_q;
         SEL_MASK: reg_rdata[NUM_SRC-1:0] = mask_q;
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/irq_regset_chk.sv
module irq_regset_chk #(
   parameter int NUM_SRC  = 7,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int STAT_OFS = 4,
   parameter int SET_OFS  = 8,
   parameter int CLR_OFS  = 12,
   parameter int MASK_OFS = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic               reg_we,
   input logic [DATA_W-1:0]  reg_wdata,
   input logic [DATA_W-1:0]  reg_rdata,
   input logic [NUM_SRC-1:0] src_evt,
   input logic               irq,
   input logic [NUM_SRC-1:0] stat_q,
   input logic [NUM_SRC-1:0] mask_q
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(SET_OFS);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_OFS);

   logic [NUM_SRC-1:0] wlo;
   logic               w_stat, w_set, w_clr;
   assign wlo    = reg_wdata[NUM_SRC-1:0];
   assign w_stat = reg_we && reg_addr == A_STAT;
   assign w_set  = reg_we && reg_addr == A_SET;
   assign w_clr  = reg_we && reg_addr == A_CLR;

   assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_evt != '0) |=> ((stat_q & $past(src_evt)) == $past(src_evt)));

   assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (w_stat && ((wlo & ~src_evt) != '0)) |=> ((stat_q & $past(wlo & ~src_evt)) == '0));

   assert_status_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!w_stat && src_evt == '0) |=> $stable(stat_q));

   assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      w_set |=> ((mask_q & $past(wlo)) == $past(wlo)));

   assert_mask_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      w_clr |=> ((mask_q & $past(wlo)) == '0));

   assert_mask_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(w_set || w_clr) |=> $stable(mask_q));

   assert_wo_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_SET || reg_addr == A_CLR) |-> reg_rdata == '0);

   assert_irq_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past(|(stat_q & mask_q))));
endmodule

bind irq_regset irq_regset_chk #(
   .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS),
   .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_addr (reg_addr),
   .reg_we   (reg_we),
   .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata),
   .src_evt  (src_evt),
   .irq      (irq),
   .stat_q   (stat_q),
   .mask_q   (mask_q)
);

// File: tb/irq_regset_tb.sv
module irq_regset_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [6:0]  src_evt = '0;
   logic        irq;

   int ntot = 0;
   int nfail = 0;
   bit done = 0;

   logic [6:0] m_stat = '0;
   logic [6:0] m_mask = '0;
   logic       m_irq = 1'b0;

   always #10 clk = ~clk;

   irq_regset u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_evt(src_evt), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      ntot++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   // drive one access at a falling edge; the rising edge in between applies it
   task automatic step(input logic [7:0] a, input logic we, input logic [31:0] wd,
                       input logic [6:0] ev);
      reg_addr = a; reg_we = we; reg_wdata = wd; src_evt = ev;
      @(negedge clk);
      m_irq = |(m_stat & m_mask);
      if (we && a == 8'h04) m_stat = m_stat & ~wd[6:0];
      m_stat = m_stat | ev;
      if (we && a == 8'h08) m_mask = m_mask | wd[6:0];
      if (we && a == 8'h0C) m_mask = m_mask & ~wd[6:0];
      reg_we = 1'b0; src_evt = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      reg_addr = a; reg_we = 1'b0;
      #1;
      v = reg_rdata;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h04, v); chk("R1 status after reset", v, 0);
      rd(8'h10, v); chk("R1 mask after reset", v, 0);
      rd(8'h08, v); chk("R1 enable offset after reset", v, 0);
      rd(8'h0C, v); chk("R1 disable offset after reset", v, 0);
      chk("R1 irq after reset", {31'd0, irq}, 0);

      // mask sweep over all 128 patterns
      for (int p = 0; p < 128; p++) begin
         logic [6:0] w;
         w = 7'((p * 37 + 11) & 127);
         step(8'h0C, 1, 32'h7F, 0);
         step(8'h08, 1, 32'hFFFF_FF00 | p, 0);
         rd(8'h10, v); chk("R5 mask set", v, {25'd0, m_mask});
         chk("R5 mask value", v, p);
         rd(8'h08, v); chk("R8 enable offset reads zero", v, 0);
         rd(8'h0C, v); chk("R8 disable offset reads zero", v, 0);
         step(8'h0C, 1, {25'h1FF_FFFF, w}, 0);
         rd(8'h10, v); chk("R6 mask clear", v, 32'(p) & ~32'(w));
         step(8'h10, 1, 32'h7F ^ 32'(p), 0);
         rd(8'h10, v); chk("R7 mask write ignored", v, 32'(p) & ~32'(w));
      end

      // status sweep over all 128 patterns
      for (int p = 0; p < 128; p++) begin
         logic [6:0] w, mk;
         w  = 7'((p * 53 + 7) & 127);
         mk = 7'((p * 5 + 3) & 127);
         step(8'h04, 1, 32'h7F, 0);
         step(8'h00, 0, 0, 7'(p));
         rd(8'h04, v); chk("R2 status set by events", v, p);
         step(8'h0C, 1, 32'h7F, 0);
         step(8'h08, 1, 32'(mk), 0);
         step(8'h00, 0, 0, 0);
         chk("R9 irq from status and mask", {31'd0, irq}, {31'd0, |(7'(p) & mk)});
         chk("R9 irq model", {31'd0, irq}, {31'd0, m_irq});
         step(8'h04, 1, 32'hFFFF_FF80 | 32'(w), 0);
         rd(8'h04, v); chk("R3 w1c clears only one bits", v, 32'(p) & ~32'(w));
         chk("R3 status model", v, {25'd0, m_stat});
         step(8'h00, 0, 0, 0);
         chk("R9 irq after clear", {31'd0, irq}, {31'd0, |(7'(p) & ~w & mk)});
         rd(8'h44, v); chk("R8 unmapped offset reads zero", v, 0);
      end

      // R4 set beats clear on every bit
      for (int i = 0; i < 7; i++) begin
         step(8'h00, 0, 0, 7'h7F);
         step(8'h04, 1, 32'h7F, 7'(1 << i));
         rd(8'h04, v); chk("R4 set wins over clear", v, 32'(1) << i);
      end

      // R10 write back of observed value
      for (int i = 0; i < 7; i++) begin
         logic [6:0] seen, late;
         seen = 7'h7F & ~7'(1 << i);
         late = 7'(1 << i);
         step(8'h04, 1, 32'h7F, 0);
         step(8'h00, 0, 0, seen);
         rd(8'h04, v);
         chk("R10 observed value", v, 32'(seen));
         step(8'h04, 1, v, late);
         rd(8'h04, v); chk("R10 write back keeps late event", v, 32'(late));
      end

      done = 1;
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         ntot++; nfail++;
         $display("FAIL watchdog R1..R10 run actual=timeout expected=complete");
         $display("%0d/%0d checks passed", ntot - nfail, ntot);
         $finish;
      end
   end
endmodule